// File: doc/BRIEF.md
# Command/Address Training Sequencer

This block runs command/address (CA) training from the controller side. The memory echoes each CA bit on a pair of data lines. The even line carries the value sampled on the rising clock edge. The odd line carries the value sampled on the falling clock edge. Only eight CA bits can be echoed at once, so the sixteen CA lines are trained in two sessions of eight. In each session the block sweeps the per-bit delay codes and records, for every bit, the first step at which the echo is correct. It then sweeps a shared clock-centering code once per session, intersects the passing ranges of the two sessions, and places the shared code at the middle of the common range.

Training starts on a one-cycle `start` pulse. When it finishes, `done` rises and stays high until the next accepted start. At that point the per-bit codes and the shared code are valid. `err` reports a failed training run. `warn` reports a run that succeeded but has little margin. The delay lines themselves are not part of this block: the delay codes are driven on the code outputs throughout, so that the delay lines follow the sweep.

Top module: `ca_train_seq`

## Requirements
- R1: During reset and directly after it, `done`, `err` and `warn` are 0, `cs_n` is 1, and every delay code is 0.
- R2: Each sweep step consists of two probes. A probe lasts REFL_LAT+1 cycles, and `cs_n` is low only in its first cycle. In the first probe `ca_rise` equals CA_PATTERN and `ca_fall` equals its complement. In the second probe both values are swapped. The CA values do not change while a probe is in progress.
- R3: In session s, data line 2j must equal the `ca_rise` value of CA bit s*8+j, and data line 2j+1 must equal its `ca_fall` value. A bit passes a step only if all four comparisons over the two probes match. A mismatch on only the even line, or on only the odd line, is enough to fail the step.
- R4: Session 0 trains CA bits 7..0 and session 1 trains CA bits 15..8. `ses_idx` gives the session number during both the deskew sweep and the centering sweep.
- R5: In the deskew sweep, every not-yet-passed bit of the session is driven with the step number, from 0 up to 63. A bit keeps the first step at which it passes. The session ends at the step where every bit of the session has passed. During the deskew sweep the shared code is held at 256.
- R6: After deskew, the shared code is swept from 0 to 511 in each session, with every bit at its deskew code. The window of a session runs from the first to the last step at which all eight bits of that session pass. The common window is [max of the lows, min of the highs]. The final shared code is floor((low+high)/2).
- R7: `err` is raised together with `done` in three cases: a bit never passes by step 63, a session has no passing centering step, or the common window is empty. When `err` is raised, all per-bit codes and the shared code are 0.
- R8: `warn` is 1 exactly when training succeeds with a common window of fewer than 8 steps (high-low+1 < 8).
- R9: With n0 and n1 the largest first-pass steps of the two sessions and X=6*(n0+n1+2), `done` rises X+6147 cycles after the start edge on success. On an error it rises earlier: 6*(steps of the earlier sessions)+384 cycles after the start edge for a deskew failure, X+3073 if session 0 has no centering pass, X+6146 if session 1 has none, and X+6147 for an empty common window. `done` then stays high, with the results unchanged, until a new start.
- R10: A `start` pulse while training is running has no effect on the results or on when `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a training run (ignored while one is running) |
| cs_n | output | 1 | Chip select, low for the first cycle of each probe |
| ca_rise | output | 16 | CA value presented for the rising edge |
| ca_fall | output | 16 | CA value presented for the falling edge |
| ses_idx | output | 1 | Current training session |
| dq_in | input | 16 | Echoed data; line 2j is the rising value and line 2j+1 the falling value of session bit j |
| bd_code | output | 96 | Per-bit delay codes, bit i in [6i+5:6i] |
| cd_code | output | 9 | Shared clock-centering delay code |
| done | output | 1 | Training finished |
| err | output | 1 | Training failed |
| warn | output | 1 | Training succeeded with a narrow window |

## Verification
Every result of a run becomes due on a single edge, the one that raises `done`. Its cycle number follows from the R9 formulas, using the largest first-pass step of each session. The bench counts edges from the start edge and compares that count with the formula. It reads codes and flags only on the falling edge after `done` is seen, and reads them again ten cycles later to confirm they have not changed. Probe-level facts are checked in the falling half of each cycle in which `cs_n` is low, because the probe values are stable there. These facts are the pattern polarity and the number of probes made in each session.

// File: rtl/ca_train_pkg.sv
package ca_train_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESK,
    ST_CENT,
    ST_MERGE,
    ST_FINAL
  } train_state_e;
endpackage

// File: rtl/ca_train_probe.sv
// Probe timing, pattern generation and echo comparison.
module ca_train_probe #(
  parameter int SES_BITS = 8,
  parameter int NUM_SES  = 2,
  parameter int REFL_LAT = 2,
  localparam int CA_W    = SES_BITS * NUM_SES,
  localparam int SSW     = (NUM_SES > 1) ? $clog2(NUM_SES) : 1,
  parameter logic [CA_W-1:0] CA_PATTERN = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic [SSW-1:0]        sess,
  input  logic [2*SES_BITS-1:0] dq_in,
  output logic                  cs_n,
  output logic [CA_W-1:0]       ca_rise,
  output logic [CA_W-1:0]       ca_fall,
  output logic                  step_end,
  output logic [SES_BITS-1:0]   step_pass
);
  localparam int PCW = $clog2(REFL_LAT + 2);

  logic [PCW-1:0]      pc_q, pc_d;
  logic                ph_q, ph_d;
  logic [SES_BITS-1:0] pv_q, pv_d;
  logic                smp;
  logic [SES_BITS-1:0] sel_r, sel_f, match;

  assign ca_rise = ph_q ? ~CA_PATTERN : CA_PATTERN;
  assign ca_fall = ~ca_rise;
  assign cs_n    = !(run && (pc_q == '0));
  assign smp     = run && (pc_q == PCW'(REFL_LAT));

  always_comb begin
    sel_r = ca_rise[int'(sess)*SES_BITS +: SES_BITS];
    sel_f = ca_fall[int'(sess)*SES_BITS +: SES_BITS];
  end

  for (genvar j = 0; j < SES_BITS; j++) begin : g_cmp
    assign match[j] = (dq_in[2*j] == sel_r[j]) && (dq_in[2*j+1] == sel_f[j]);
  end

  always_comb begin
    pc_d = pc_q;
    ph_d = ph_q;
    pv_d = pv_q;
    if (!run) begin
      pc_d = '0;
      ph_d = 1'b0;
    end else if (smp) begin
      pc_d = '0;
      ph_d = ~ph_q;
      if (!ph_q) pv_d = match;
    end else begin
      pc_d = pc_q + 1'b1;
    end
  end

  assign step_end  = smp && ph_q;
  assign step_pass = pv_q & match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      ph_q <= 1'b0;
      pv_q <= '0;
    end else begin
      pc_q <= pc_d;
      ph_q <= ph_d;
      pv_q <= pv_d;
    end
  end
endmodule

// File: rtl/ca_train_deskew.sv
// Per-bit delay codes and first-pass capture.
module ca_train_deskew #(
  parameter int SES_BITS = 8,
  parameter int NUM_SES  = 2,
  parameter int BD_W     = 6,
  localparam int CA_W    = SES_BITS * NUM_SES,
  localparam int SSW     = (NUM_SES > 1) ? $clog2(NUM_SES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_all,
  input  logic                   ses_clr,
  input  logic                   step_end,
  input  logic [SSW-1:0]         sess,
  input  logic [SES_BITS-1:0]    step_pass,
  output logic [CA_W*BD_W-1:0]   bd_flat,
  output logic                   all_found
);
  logic [BD_W-1:0]     bd_q [CA_W];
  logic [BD_W-1:0]     bd_d [CA_W];
  logic [SES_BITS-1:0] found_q, found_d;
  logic                bd_en;

  assign all_found = &(found_q | step_pass);
  assign bd_en     = clr_all || step_end;

  always_comb begin
    for (int i = 0; i < CA_W; i++) bd_d[i] = bd_q[i];
    if (clr_all) begin
      for (int i = 0; i < CA_W; i++) bd_d[i] = '0;
    end else if (step_end) begin
      for (int s = 0; s < NUM_SES; s++) begin
        for (int j = 0; j < SES_BITS; j++) begin
          if ((sess == SSW'(s)) && !found_q[j] && !step_pass[j])
            bd_d[s*SES_BITS+j] = bd_q[s*SES_BITS+j] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    found_d = found_q;
    if (clr_all || ses_clr) found_d = '0;
    else if (step_end)      found_d = found_q | step_pass;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CA_W; i++) bd_q[i] <= '0;
      found_q <= '0;
    end else begin
      if (bd_en) begin
        for (int i = 0; i < CA_W; i++) bd_q[i] <= bd_d[i];
      end
      found_q <= found_d;
    end
  end

  for (genvar i = 0; i < CA_W; i++) begin : g_out
    assign bd_flat[i*BD_W +: BD_W] = bd_q[i];
  end
endmodule

// File: rtl/ca_train_window.sv
// Centering window tracking per session and across sessions.
module ca_train_window #(
  parameter int CD_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ses_clr,
  input  logic            upd,
  input  logic            pass_all,
  input  logic [CD_W-1:0] step,
  input  logic            merge,
  input  logic            first,
  output logic            seen,
  output logic [CD_W-1:0] win_lo,
  output logic [CD_W-1:0] win_hi
);
  logic            seen_q, seen_d;
  logic [CD_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic [CD_W-1:0] wlo_q, wlo_d, whi_q, whi_d;
  logic            hit;

  assign hit = upd && pass_all;

  always_comb begin
    seen_d = seen_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    if (ses_clr) begin
      seen_d = 1'b0;
    end else if (hit) begin
      seen_d = 1'b1;
      hi_d   = step;
      if (!seen_q) lo_d = step;
    end
  end

  always_comb begin
    wlo_d = wlo_q;
    whi_d = whi_q;
    if (merge) begin
      wlo_d = (first || (lo_q > wlo_q)) ? lo_q : wlo_q;
      whi_d = (first || (hi_q < whi_q)) ? hi_q : whi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
      wlo_q  <= '0;
      whi_q  <= '0;
    end else begin
      seen_q <= seen_d;
      if (hit) begin
        lo_q <= lo_d;
        hi_q <= hi_d;
      end
      if (merge) begin
        wlo_q <= wlo_d;
        whi_q <= whi_d;
      end
    end
  end

  assign seen   = seen_q;
  assign win_lo = wlo_q;
  assign win_hi = whi_q;
endmodule

// File: rtl/ca_train_seq.sv
// Two-session CA deskew and clock-centering sequencer.
module ca_train_seq
  import ca_train_pkg::*;
#(
  parameter int SES_BITS = 8,
  parameter int NUM_SES  = 2,
  parameter int BD_W     = 6,
  parameter int CD_W     = 9,
  parameter int REFL_LAT = 2,
  parameter int WARN_MIN = 8,
  localparam int CA_W    = SES_BITS * NUM_SES,
  localparam int SSW     = (NUM_SES > 1) ? $clog2(NUM_SES) : 1,
  parameter logic [CA_W-1:0] CA_PATTERN = 16'hC35A
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic                  cs_n,
  output logic [CA_W-1:0]       ca_rise,
  output logic [CA_W-1:0]       ca_fall,
  output logic [SSW-1:0]        ses_idx,
  input  logic [2*SES_BITS-1:0] dq_in,
  output logic [CA_W*BD_W-1:0]  bd_code,
  output logic [CD_W-1:0]       cd_code,
  output logic                  done,
  output logic                  err,
  output logic                  warn
);
  localparam int STW     = (CD_W > BD_W) ? CD_W : BD_W;
  localparam int BD_MAX  = (1 << BD_W) - 1;
  localparam int CD_MAX  = (1 << CD_W) - 1;
  localparam int CD_INIT = 1 << (CD_W - 1);

  train_state_e        st_q, st_d;
  logic [SSW-1:0]      sess_q, sess_d;
  logic [STW-1:0]      step_q, step_d;
  logic [CD_W-1:0]     cd_q, cd_d;
  logic                done_q, done_d, err_q, err_d, warn_q, warn_d;

  logic                run, step_end, all_found, seen;
  logic [SES_BITS-1:0] step_pass;
  logic                dsk_clr, dsk_ses_clr, win_ses_clr, win_merge;
  logic [CD_W-1:0]     win_lo, win_hi;
  logic [CD_W:0]       win_sum, win_len;
  logic                last_ses;

  assign run      = (st_q == ST_DESK) || (st_q == ST_CENT);
  assign last_ses = (sess_q == SSW'(NUM_SES - 1));
  assign win_sum  = {1'b0, win_lo} + {1'b0, win_hi};
  assign win_len  = {1'b0, win_hi} - {1'b0, win_lo} + 1'b1;

  ca_train_probe #(
    .SES_BITS(SES_BITS), .NUM_SES(NUM_SES), .REFL_LAT(REFL_LAT),
    .CA_PATTERN(CA_PATTERN)
  ) u_probe (
    .clk(clk), .rst_n(rst_n), .run(run), .sess(sess_q), .dq_in(dq_in),
    .cs_n(cs_n), .ca_rise(ca_rise), .ca_fall(ca_fall),
    .step_end(step_end), .step_pass(step_pass)
  );

  ca_train_deskew #(
    .SES_BITS(SES_BITS), .NUM_SES(NUM_SES), .BD_W(BD_W)
  ) u_deskew (
    .clk(clk), .rst_n(rst_n), .clr_all(dsk_clr), .ses_clr(dsk_ses_clr),
    .step_end(step_end && (st_q == ST_DESK)), .sess(sess_q),
    .step_pass(step_pass), .bd_flat(bd_code), .all_found(all_found)
  );

  ca_train_window #(
    .CD_W(CD_W)
  ) u_window (
    .clk(clk), .rst_n(rst_n), .ses_clr(win_ses_clr),
    .upd(step_end && (st_q == ST_CENT)), .pass_all(&step_pass),
    .step(step_q[CD_W-1:0]), .merge(win_merge), .first(sess_q == '0),
    .seen(seen), .win_lo(win_lo), .win_hi(win_hi)
  );

  always_comb begin
    st_d        = st_q;
    sess_d      = sess_q;
    step_d      = step_q;
    cd_d        = cd_q;
    done_d      = done_q;
    err_d       = err_q;
    warn_d      = warn_q;
    dsk_clr     = 1'b0;
    dsk_ses_clr = 1'b0;
    win_ses_clr = 1'b0;
    win_merge   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d    = ST_DESK;
          sess_d  = '0;
          step_d  = '0;
          cd_d    = CD_W'(CD_INIT);
          done_d  = 1'b0;
          err_d   = 1'b0;
          warn_d  = 1'b0;
          dsk_clr = 1'b1;
        end
      end
      ST_DESK: begin
        if (step_end) begin
          if (all_found) begin
            step_d = '0;
            if (last_ses) begin
              st_d        = ST_CENT;
              sess_d      = '0;
              cd_d        = '0;
              win_ses_clr = 1'b1;
            end else begin
              sess_d      = sess_q + 1'b1;
              dsk_ses_clr = 1'b1;
            end
          end else if (step_q == STW'(BD_MAX)) begin
            st_d    = ST_IDLE;
            done_d  = 1'b1;
            err_d   = 1'b1;
            cd_d    = '0;
            dsk_clr = 1'b1;
          end else begin
            step_d = step_q + 1'b1;
          end
        end
      end
      ST_CENT: begin
        if (step_end) begin
          if (step_q == STW'(CD_MAX)) begin
            st_d = ST_MERGE;
          end else begin
            step_d = step_q + 1'b1;
            cd_d   = step_d[CD_W-1:0];
          end
        end
      end
      ST_MERGE: begin
        if (!seen) begin
          st_d    = ST_IDLE;
          done_d  = 1'b1;
          err_d   = 1'b1;
          cd_d    = '0;
          dsk_clr = 1'b1;
        end else begin
          win_merge = 1'b1;
          if (last_ses) begin
            st_d = ST_FINAL;
          end else begin
            st_d        = ST_CENT;
            sess_d      = sess_q + 1'b1;
            step_d      = '0;
            cd_d        = '0;
            win_ses_clr = 1'b1;
          end
        end
      end
      ST_FINAL: begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
        if (win_lo > win_hi) begin
          err_d   = 1'b1;
          cd_d    = '0;
          dsk_clr = 1'b1;
        end else begin
          cd_d   = win_sum[CD_W:1];
          warn_d = (win_len < (CD_W+1)'(WARN_MIN));
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sess_q <= '0;
      step_q <= '0;
      cd_q   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      warn_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sess_q <= sess_d;
      step_q <= step_d;
      cd_q   <= cd_d;
      done_q <= done_d;
      err_q  <= err_d;
      warn_q <= warn_d;
    end
  end

  assign ses_idx = sess_q;
  assign cd_code = cd_q;
  assign done    = done_q;
  assign err     = err_q;
  assign warn    = warn_q;
endmodule

// File: rtl/ca_train_seq_chk.sv
module ca_train_seq_chk #(
  parameter int CA_W = 16,
  parameter int BD_W = 6,
  parameter int CD_W = 9,
  parameter int SSW  = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 cs_n,
  input logic [CA_W-1:0]      ca_rise,
  input logic [SSW-1:0]       ses_idx,
  input logic [CA_W*BD_W-1:0] bd_code,
  input logic [CD_W-1:0]      cd_code,
  input logic                 done,
  input logic                 err,
  input logic                 warn
);
  // R7
  err_codes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> ((bd_code == '0) && (cd_code == '0)));

  // R8
  warn_only_success_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warn |-> (done && !err));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R9
  no_probe_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !done);

  // R2
  cs_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> cs_n);

  // R2
  ca_held_in_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> $stable(ca_rise));

  // R4
  ses_held_in_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> $stable(ses_idx));

  // R10
  restart_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && done) |=> !done);
endmodule

bind ca_train_seq ca_train_seq_chk #(
  .CA_W(SES_BITS*NUM_SES), .BD_W(BD_W), .CD_W(CD_W),
  .SSW((NUM_SES > 1) ? $clog2(NUM_SES) : 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs_n), .ca_rise(ca_rise),
  .ses_idx(ses_idx), .bd_code(bd_code), .cd_code(cd_code),
  .done(done), .err(err), .warn(warn)
);

// File: tb/ca_train_seq_bench.sv
module ca_train_seq_bench;
  localparam logic [15:0] PAT = 16'hC35A;

  logic        clk, rst_n, start, cs_n, done, err, warn;
  logic [15:0] ca_rise, ca_fall, dq_q;
  logic [0:0]  ses_idx;
  logic [95:0] bd_code;
  logic [8:0]  cd_code;

  ca_train_seq u_ca_train_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs_n),
    .ca_rise(ca_rise), .ca_fall(ca_fall), .ses_idx(ses_idx), .dq_in(dq_q),
    .bd_code(bd_code), .cd_code(cd_code), .done(done), .err(err), .warn(warn)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  bit summary_done = 0;

  int blo[16], bhi[16], clo[16], chi[16];
  int cmode = 0;
  bit cent_seen = 0;

  int pcount, s1count, pat_bad;

  // Memory echo model: a bit echoes correctly when its per-bit code is inside
  // its window and, once centering has begun, the shared code is too.
  always @(posedge clk) begin
    if (!cs_n) begin
      for (int j = 0; j < 8; j++) begin
        automatic int i = ses_idx * 8 + j;
        automatic int b = bd_code[i*6 +: 6];
        automatic int c = cd_code;
        automatic bit ok = (b >= blo[i]) && (b <= bhi[i]) &&
                           (!(cent_seen || c != 256) || (c >= clo[i] && c <= chi[i]));
        dq_q[2*j]   <= ca_rise[i] ^ (!ok && cmode != 2);
        dq_q[2*j+1] <= ca_fall[i] ^ (!ok && cmode != 1);
      end
      if (cd_code != 9'd256) cent_seen <= 1'b1;
    end
  end

  always @(negedge clk) begin
    if (!cs_n) begin
      if (ca_rise !== (pcount[0] ? ~PAT : PAT) || ca_fall !== ~ca_rise) pat_bad++;
      if (ses_idx == 1'b1) s1count++;
      pcount++;
    end
  end

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [95:0] e_bd;
  int e_cd, e_T, e_probes, e_s1;
  bit e_err, e_warn;

  task automatic compute_expect();
    int n[2];
    int base, slo[2], shi[2], wlo, whi;
    e_bd = '0; e_cd = 0; e_err = 0; e_warn = 0; e_T = 0; e_probes = -1; e_s1 = -1;
    base = 0;
    for (int s = 0; s < 2; s++) begin
      bit bad = 0;
      n[s] = 0;
      for (int j = 0; j < 8; j++) begin
        int i = s * 8 + j;
        if (blo[i] > 63 || blo[i] > bhi[i]) bad = 1;
        else if (blo[i] > n[s]) n[s] = blo[i];
      end
      if (bad) begin
        e_err = 1; e_T = base + 384;
        return;
      end
      base += 6 * (n[s] + 1);
    end
    for (int s = 0; s < 2; s++) begin
      slo[s] = 0; shi[s] = 511;
      for (int j = 0; j < 8; j++) begin
        int i = s * 8 + j;
        if (clo[i] > slo[s]) slo[s] = clo[i];
        if (chi[i] < shi[s]) shi[s] = chi[i];
      end
      if (slo[s] > shi[s]) begin
        e_err = 1; e_T = base + ((s == 0) ? 3073 : 6146);
        return;
      end
    end
    e_T = base + 6147;
    e_probes = 2 * (n[0] + n[1] + 2) + 2048;
    e_s1 = 2 * (n[1] + 1) + 1024;
    wlo = (slo[0] > slo[1]) ? slo[0] : slo[1];
    whi = (shi[0] < shi[1]) ? shi[0] : shi[1];
    if (wlo > whi) begin
      e_err = 1;
      return;
    end
    for (int i = 0; i < 16; i++) e_bd[i*6 +: 6] = 6'(blo[i]);
    e_cd = (wlo + whi) / 2;
    e_warn = (whi - wlo + 1) < 8;
  endtask

  task automatic run_case(string name, int inj0, int inj1);
    int cnt;
    bit got;
    logic [95:0] bd_snap;
    logic [8:0]  cd_snap;
    compute_expect();
    @(negedge clk);
    cent_seen = 0; pcount = 0; s1count = 0; pat_bad = 0;
    start = 1'b1;
    cnt = 0; got = 0;
    while (!got && cnt < 20000) begin
      @(posedge clk);
      @(negedge clk);
      start = (cnt == inj0 || cnt == inj1) ? 1'b1 : 1'b0;
      if (done) got = 1;
      else cnt++;
    end
    start = 1'b0;
    // R9 R10: done due exactly e_T edges after the start edge
    check(got && cnt == e_T, "R9/R10", {name, " done latency"}, cnt, e_T);
    // R7
    check(err == e_err, "R7", {name, " err"}, err, e_err);
    // R8
    check(warn == e_warn, "R8", {name, " warn"}, warn, e_warn);
    // R5 R7
    check(bd_code == e_bd, "R5", {name, " per-bit codes"}, bd_code, e_bd);
    // R6 R7
    check(cd_code == 9'(e_cd), "R6", {name, " centering code"}, cd_code, e_cd);
    // R2 R3
    check(pat_bad == 0, "R2", {name, " probe pattern"}, pat_bad, 0);
    if (e_probes >= 0) begin
      check(pcount == e_probes, "R2", {name, " probe count"}, pcount, e_probes);
      // R4
      check(s1count == e_s1, "R4", {name, " session-1 probes"}, s1count, e_s1);
    end
    bd_snap = bd_code; cd_snap = cd_code;
    repeat (10) @(negedge clk);
    check(done && bd_code == bd_snap && cd_code == cd_snap && cs_n,
          "R9", {name, " results held"}, {done, cd_code}, {1'b1, cd_snap});
  endtask

  task automatic set_base();
    for (int i = 0; i < 16; i++) begin
      blo[i] = (i * 5) % 23; bhi[i] = blo[i] + 10;
      clo[i] = 120 + i * 3;  chi[i] = 400 - i * 2;
    end
    cmode = 0;
  endtask

  initial begin
    #(8 * 190000);
    $display("FAIL watchdog expired");
    failures++;
    if (!summary_done) begin
      summary_done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    set_base();
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check(!done && !err && !warn && cs_n && bd_code == '0 && cd_code == '0,
          "R1", "reset state", {done, err, warn, cs_n}, 4'b0001);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && cs_n && bd_code == '0, "R1", "after release", {done, cs_n}, 2'b01);

    set_base(); run_case("base", -1, -1);
    set_base(); run_case("start-ignored", 100, 3000); // R10
    set_base(); cmode = 1; run_case("rise-only-miss", -1, -1); // R3
    set_base(); cmode = 2; run_case("fall-only-miss", -1, -1); // R3
    set_base();
    for (int i = 0; i < 16; i++) begin clo[i] = 250; chi[i] = 256; end
    run_case("width7-warn", -1, -1); // R8
    set_base();
    for (int i = 0; i < 16; i++) begin clo[i] = 250; chi[i] = 257; end
    run_case("width8-nowarn", -1, -1); // R8
    set_base(); blo[11] = 70; run_case("bit-never-passes", -1, -1); // R7
    set_base(); blo[3] = 63; bhi[3] = 63; run_case("last-step-pass", -1, -1); // R5
    set_base();
    for (int i = 0; i < 16; i++) begin
      clo[i] = (i < 8) ? 10 : 200; chi[i] = (i < 8) ? 100 : 300;
    end
    run_case("empty-common", -1, -1); // R7
    set_base(); clo[2] = 0; chi[2] = 50; clo[3] = 60; chi[3] = 100;
    run_case("session0-no-window", -1, -1); // R7
    set_base(); clo[12] = 0; chi[12] = 50; clo[13] = 60; chi[13] = 100;
    run_case("session1-no-window", -1, -1); // R7
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 16; i++) begin
        blo[i] = $urandom_range(40, 0); bhi[i] = blo[i] + $urandom_range(20, 3);
        clo[i] = $urandom_range(260, 0); chi[i] = clo[i] + $urandom_range(240, 20);
        if (chi[i] > 511) chi[i] = 511;
      end
      cmode = $urandom_range(2, 0);
      run_case($sformatf("random%0d", r), -1, -1);
    end
    if (!summary_done) begin
      summary_done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end
endmodule